// File: doc/BRIEF.md
# DMA Address Step Selector

This block decides, on every cycle, how far the read-side and the write-side address counters of a DMA engine advance per transferred beat. It does not hold the addresses. It only produces two step values that the address counters add after each beat.

There are three sources for a step, in priority order. A hold flag forces both steps to zero, so a fixed peripheral address is used. When no override is in force, the step follows the transfer size chosen in the control bits. When a side has a nonzero software override, the step is that override value. Each side has its own override register, which lives outside this block. Whether that register is zero is captured into a registered flag at the moment software writes it, and the test uses the write data. This keeps the wide zero compare out of the per-beat path. A side built with a zero-width override has no flag, and it always uses the size-derived step.

Top module: `dma_step_select`

## Requirements
- R1: While `hold_addr_i` is 1, both `rd_step_o` and `wr_step_o` are 0, whatever the size bits and override state.
- R2: When a side's zero flag is set and `hold_addr_i` is 0, that side's step comes from `xfer_size_i`. Bit 2 set gives 4. Otherwise bit 1 set gives 2. Otherwise bit 0 set gives 1. No bit set gives 0. The widest set size wins when several bits are set.
- R3: When a side's zero flag is clear and `hold_addr_i` is 0, that side's step equals its override contents input, zero-extended to the step width.
- R4: A 1 on a side's write strobe loads that side's zero flag with (low override-width bits of `reg_wdata_i` == 0). The new flag governs the step from the cycle after the strobe edge. Data bits above the override width are ignored.
- R5: Without a write strobe, a side's zero flag holds its value. A change of the override contents input alone does not switch that side between size-derived and override steps.
- R6: After reset, a side's zero flag is 1 if that side's override reset value parameter is 0, and 0 otherwise. Reset is asserted asynchronously and released through a two-stage synchronizer.
- R7: A side built with override width 0 always uses the size-derived step. Its strobe, write data and contents inputs have no effect.
- R8: The sides are independent. A strobe on one side never changes the other side's zero flag or step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_addr_i | input | 1 | Constant-address mode, forces both steps to 0 |
| xfer_size_i | input | 3 | Transfer size bits: bit0 byte, bit1 halfword, bit2 word |
| reg_wdata_i | input | DATA_W | Register write data bus |
| rd_ovr_we_i | input | 1 | Write strobe of the read override register |
| wr_ovr_we_i | input | 1 | Write strobe of the write override register |
| rd_ovr_i | input | max(RD_OVR_W,1) | Read override register contents |
| wr_ovr_i | input | max(WR_OVR_W,1) | Write override register contents |
| rd_step_o | output | STEP_W | Read address step per beat |
| wr_step_o | output | STEP_W | Write address step per beat |

## Verification
The main instance is built with a 4-bit read override that resets to 0 and a 3-bit write override that resets to 5. The two sides therefore come out of reset in opposite modes, which covers both reset values of the flag. The width of 4 leaves every override value open to a full sweep: each override is crossed with all eight size codes and both hold settings, with write data that carries stray upper bits. A second instance has both override widths set to 0. Against it, every size code is swept while strobes and override contents toggle, which shows that a missing override register has no effect.

// File: rtl/dma_step_pkg.sv
package dma_step_pkg;

  localparam int SIZE_BITS = 3;
  localparam int SZ_BYTE   = 0;
  localparam int SZ_HALF   = 1;
  localparam int SZ_WORD   = 2;

  function automatic logic [2:0] size_to_step(input logic [SIZE_BITS-1:0] sz);
    logic [2:0] s;
    if (sz[SZ_WORD])      s = 3'd4;
    else if (sz[SZ_HALF]) s = 3'd2;
    else if (sz[SZ_BYTE]) s = 3'd1;
    else                  s = 3'd0;
    return s;
  endfunction

endpackage

// File: rtl/step_rst_sync.sv
module step_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/step_size_decode.sv
module step_size_decode
  import dma_step_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic [SIZE_BITS-1:0] size_i,
  output logic [STEP_W-1:0]    step_o
);

  logic [2:0] raw_step;

  always_comb begin
    raw_step = size_to_step(size_i);
    step_o   = STEP_W'(raw_step);
  end

  always_comb begin
    AST_STEP_POW2: assert ($countones(step_o) <= 1) else $error("size step not a power of two"); // R2
  end

endmodule

// File: rtl/step_side.sv
module step_side #(
  parameter int OVR_W   = 4,
  parameter int OVR_PW  = 4,
  parameter int OVR_RST = 0,
  parameter int STEP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic [STEP_W-1:0] size_step_i,
  input  logic              ovr_we_i,
  input  logic [OVR_PW-1:0] wdata_i,
  input  logic [OVR_PW-1:0] ovr_i,
  output logic [STEP_W-1:0] step_o
);

  logic zero_flag;

  generate
    if (OVR_W == 0) begin : g_no_ovr
      logic unused_inputs;
      assign unused_inputs = ^{ovr_we_i, wdata_i, ovr_i};
      assign zero_flag = 1'b1;

      always_comb begin
        step_o = hold_i ? '0 : size_step_i;
      end

      AST_NO_OVR_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |-> step_o == size_step_i) else $error("width-0 side left size step"); // R7
    end else begin : g_ovr
      localparam logic FLAG_RST = (OVR_RST == 0);

      logic flag_q;
      logic flag_d;
      logic flag_en;

      always_comb begin
        flag_en = ovr_we_i;
        flag_d  = (wdata_i[OVR_W-1:0] == '0);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= FLAG_RST;
        else if (flag_en) flag_q <= flag_d;
      end

      assign zero_flag = flag_q;

      always_comb begin
        if (hold_i)         step_o = '0;
        else if (zero_flag) step_o = size_step_i;
        else                step_o = STEP_W'(ovr_i[OVR_W-1:0]);
      end

      AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_we_i |=> zero_flag == ($past(wdata_i[OVR_W-1:0]) == '0)) else $error("flag load wrong"); // R4
      AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_we_i |=> $stable(zero_flag)) else $error("flag moved without strobe"); // R5
      AST_OVR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !zero_flag) |-> step_o == STEP_W'(ovr_i[OVR_W-1:0])) else $error("override not used"); // R3
    end
  endgenerate

endmodule

// File: rtl/dma_step_select.sv
module dma_step_select
  import dma_step_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RD_OVR_W   = 4,
  parameter int WR_OVR_W   = 3,
  parameter int RD_OVR_RST = 0,
  parameter int WR_OVR_RST = 5,
  localparam int RD_PW     = (RD_OVR_W == 0) ? 1 : RD_OVR_W,
  localparam int WR_PW     = (WR_OVR_W == 0) ? 1 : WR_OVR_W,
  localparam int OVR_MAX   = (RD_OVR_W > WR_OVR_W) ? RD_OVR_W : WR_OVR_W,
  localparam int STEP_W    = (OVR_MAX > 3) ? OVR_MAX : 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold_addr_i,
  input  logic [SIZE_BITS-1:0] xfer_size_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  input  logic                 rd_ovr_we_i,
  input  logic                 wr_ovr_we_i,
  input  logic [RD_PW-1:0]     rd_ovr_i,
  input  logic [WR_PW-1:0]     wr_ovr_i,
  output logic [STEP_W-1:0]    rd_step_o,
  output logic [WR_PW-1+STEP_W-WR_PW:0] wr_step_o
);

  logic              rst_sync_n;
  logic [STEP_W-1:0] size_step;

  step_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  step_size_decode #(.STEP_W(STEP_W)) u_size (
    .size_i (xfer_size_i),
    .step_o (size_step)
  );

  step_side #(
    .OVR_W   (RD_OVR_W),
    .OVR_PW  (RD_PW),
    .OVR_RST (RD_OVR_RST),
    .STEP_W  (STEP_W)
  ) u_rd (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .hold_i      (hold_addr_i),
    .size_step_i (size_step),
    .ovr_we_i    (rd_ovr_we_i),
    .wdata_i     (reg_wdata_i[RD_PW-1:0]),
    .ovr_i       (rd_ovr_i),
    .step_o      (rd_step_o)
  );

  step_side #(
    .OVR_W   (WR_OVR_W),
    .OVR_PW  (WR_PW),
    .OVR_RST (WR_OVR_RST),
    .STEP_W  (STEP_W)
  ) u_wr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .hold_i      (hold_addr_i),
    .size_step_i (size_step),
    .ovr_we_i    (wr_ovr_we_i),
    .wdata_i     (reg_wdata_i[WR_PW-1:0]),
    .ovr_i       (wr_ovr_i),
    .step_o      (wr_step_o)
  );

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_addr_i |-> (rd_step_o == '0 && wr_step_o == '0)) else $error("hold mode step nonzero"); // R1
  AST_SIZE_NOT_WIDER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xfer_size_i == '0 |-> size_step == '0) else $error("empty size gave a step"); // R2

endmodule

// File: tb/tb_dma_step_select.sv
module tb_dma_step_select;

  localparam int DATA_W = 32;
  localparam int RD_W   = 4;
  localparam int WR_W   = 3;
  localparam int WR_RST = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold;
  logic [2:0]  size;
  logic [31:0] wdata;
  logic        rd_we, wr_we;
  logic [3:0]  rd_ovr;
  logic [2:0]  wr_ovr;
  logic [3:0]  rd_step, wr_step;
  logic        z_rd_ovr, z_wr_ovr;
  logic [2:0]  z_rd_step, z_wr_step;

  int checks = 0;
  int fails  = 0;
  logic rd_flag_m, wr_flag_m;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  dma_step_select #(.DATA_W(DATA_W), .RD_OVR_W(RD_W), .WR_OVR_W(WR_W),
                    .RD_OVR_RST(0), .WR_OVR_RST(WR_RST)) dut (
    .clk(clk), .rst_n(rst_n), .hold_addr_i(hold), .xfer_size_i(size),
    .reg_wdata_i(wdata), .rd_ovr_we_i(rd_we), .wr_ovr_we_i(wr_we),
    .rd_ovr_i(rd_ovr), .wr_ovr_i(wr_ovr), .rd_step_o(rd_step), .wr_step_o(wr_step));

  dma_step_select #(.DATA_W(DATA_W), .RD_OVR_W(0), .WR_OVR_W(0),
                    .RD_OVR_RST(0), .WR_OVR_RST(0)) dut_z (
    .clk(clk), .rst_n(rst_n), .hold_addr_i(hold), .xfer_size_i(size),
    .reg_wdata_i(wdata), .rd_ovr_we_i(rd_we), .wr_ovr_we_i(wr_we),
    .rd_ovr_i(z_rd_ovr), .wr_ovr_i(z_wr_ovr), .rd_step_o(z_rd_step), .wr_step_o(z_wr_step));

  function automatic int size_step(input logic [2:0] s);
    if (s[2]) return 4;
    if (s[1]) return 2;
    if (s[0]) return 1;
    return 0;
  endfunction

  function automatic int exp_step(input logic h, input logic f, input logic [2:0] s, input int ovr);
    if (h) return 0;
    if (f) return size_step(s);
    return ovr;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (size=%b hold=%b rd_ovr=%0d wr_ovr=%0d)",
               req, act, exp, size, hold, rd_ovr, wr_ovr);
    end
  endtask

  // strobes one or both sides, upper data bits carry junk (R4)
  task automatic write_ovr(input logic do_rd, input logic do_wr, input logic [3:0] val);
    @(negedge clk);
    wdata = {28'hA5C3F00, val} | 32'hFFFF_FF00;
    rd_we = do_rd;
    wr_we = do_wr;
    if (do_rd) begin rd_ovr = val;      rd_flag_m = (val == 4'd0);      end
    if (do_wr) begin wr_ovr = val[2:0]; wr_flag_m = (val[2:0] == 3'd0); end
    @(negedge clk);
    rd_we = 1'b0;
    wr_we = 1'b0;
    wdata = 32'h0;
  endtask

  task automatic sweep_both(input string req);
    for (int h = 0; h < 2; h++) begin
      for (int s = 0; s < 8; s++) begin
        @(negedge clk);
        hold = h[0];
        size = s[2:0];
        #1;
        check(h ? "R1" : req, int'(rd_step), exp_step(hold, rd_flag_m, size, int'(rd_ovr)));
        check(h ? "R1" : req, int'(wr_step), exp_step(hold, wr_flag_m, size, int'(wr_ovr)));
      end
    end
  endtask

  initial begin
    hold = 1'b0; size = 3'b000; wdata = '0; rd_we = 1'b0; wr_we = 1'b0;
    rd_ovr = 4'd0; wr_ovr = 3'(WR_RST); z_rd_ovr = 1'b0; z_wr_ovr = 1'b0;
    rd_flag_m = 1'b1; wr_flag_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: reset values of the flags
    size = 3'b010;
    #1;
    check("R6", int'(rd_step), 2);
    check("R6", int'(wr_step), WR_RST);

    // R2: size decode incl. priority with flag set
    write_ovr(1'b1, 1'b1, 4'd0);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      size = s[2:0];
      #1;
      check("R2", int'(rd_step), size_step(size));
      check("R2", int'(wr_step), size_step(size));
    end

    // R5: contents change without strobe leaves size mode
    @(negedge clk);
    size = 3'b001;
    rd_ovr = 4'd7;
    #1;
    check("R5", int'(rd_step), 1);

    // R8: read strobe does not touch write side
    write_ovr(1'b1, 1'b0, 4'd9);
    #1;
    check("R8", int'(wr_step), 1);
    check("R3", int'(rd_step), 9);

    // R3/R4: full sweep of override values on both sides
    for (int v = 0; v < 16; v++) begin
      write_ovr(1'b1, 1'b1, v[3:0]);
      sweep_both(v == 0 ? "R4" : "R3");
    end

    // R7: width-0 instance ignores strobes and contents
    for (int v = 0; v < 8; v++) begin
      write_ovr(1'b1, 1'b1, v[3:0] + 4'd1);
      for (int s = 0; s < 8; s++) begin
        @(negedge clk);
        hold = 1'b0;
        size = s[2:0];
        z_rd_ovr = v[0];
        z_wr_ovr = ~v[0];
        #1;
        check("R7", int'(z_rd_step), size_step(size));
        check("R7", int'(z_wr_step), size_step(size));
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin : run
        wait (done);
      end
      begin : dog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule